// File: doc/BRIEF.md
# Snoop Invalidation and Whole-Cache Flush Controller

This block sits between the external coherency pins and the tag array of an on-chip cache. When another bus master raises the address-hold request, the block stops driving only the address pins, starting one clock later. The other master can then place a snoop address on those pins. A strobe, active low, marks that address as valid. The captured address becomes an invalidate command toward the tags: a matching line loses its valid bit, and a non-matching address changes nothing. The data path, including line fills and lookups, keeps running throughout.

A separate active-low flush input may arrive asynchronously. It passes through a synchroniser and an edge detector, so that one pulse of any length starts exactly one flush. The flush walks every set, clears one set per clock, and raises a busy flag for the whole walk. Snoop strobes that arrive during a flush wait in a small ordered queue and are issued one per clock once the walk ends.

The cache is direct mapped with `SETS` sets. An address splits into an offset of `OFF_W` bits, an index of log2(`SETS`) bits above it, and a tag in the remaining upper bits. The tag array is part of the block and has a fill port and a lookup port, so its state can be seen at the ports.

Top module: `snp_coherency_ctrl`

## Requirements
- R1: After reset, `addr_oe_o` is 1, `flush_busy_o` is 0, `inv_valid_o` is 0 and no lookup hits.
- R2: `addr_oe_o` falls in the clock after `ahold_i` is sampled high and rises in the clock after `ahold_i` is sampled low. A one-clock hold request floats the address bus for exactly one clock.
- R3: Address hold affects only `addr_oe_o`. Fills and lookups made while it is active behave exactly as they do without it.
- R4: When `eads_ni` is sampled low at an edge, `snoop_addr_i` is captured. If no flush is running and no earlier request is pending, `inv_valid_o` is 1 in the following clock and `inv_addr_o` equals the captured address.
- R5: During an `inv_valid_o` clock, `inv_hit_o` is 1 exactly when the line is present. A line is present when the set at index bits [5:2] (default widths) is valid and its stored tag equals bits [15:6]. On a hit the line is no longer present from the next clock. Offset bits [1:0] do not affect the match.
- R6: An invalidation that misses, either on tag or on index, leaves every line unchanged.
- R7: `flush_ni` sampled low at edge E0 raises `flush_busy_o` after edge E0+2. Busy then stays high for exactly `SETS` clocks. A low level held for many clocks starts only one flush.
- R8: When `flush_busy_o` has fallen, no line is present.
- R9: `inv_valid_o` is never 1 while `flush_busy_o` is 1. Strobes sampled during a flush are issued after it ends, one per clock, in arrival order, up to `Q_DEPTH` of them. Strobes that arrive while the queue is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ahold_i | input | 1 | Address-hold request, active high |
| eads_ni | input | 1 | Snoop address valid strobe, active low |
| snoop_addr_i | input | ADDR_W | Address driven by the other master |
| flush_ni | input | 1 | Asynchronous whole-cache flush request, active low |
| fill_i | input | 1 | Install a line |
| fill_addr_i | input | ADDR_W | Address of the line to install |
| lk_addr_i | input | ADDR_W | Lookup address |
| addr_oe_o | output | 1 | Address bus output enable |
| inv_valid_o | output | 1 | Invalidate command issued this clock |
| inv_addr_o | output | ADDR_W | Address of the issued invalidate |
| inv_hit_o | output | 1 | Issued invalidate matches a present line |
| flush_busy_o | output | 1 | Flush walk in progress |
| lk_hit_o | output | 1 | Lookup address is present |

## Verification
A stuck or mis-set valid bit appears at `lk_hit_o` in the very clock after the fill, invalidate or flush step that should have changed it. A wrong set counter appears as a busy window of the wrong length. A damaged queue pointer appears when the queued invalidates are issued after a flush: the addresses come out of order, or too many or too few of them appear. Each of these is visible within `SETS` + `Q_DEPTH` clocks of its cause. A wrong synchroniser depth or a missing edge detector shows up as a shifted rise of busy, or as a second walk.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_RUN  = 1'b1
  } flush_state_e;
endpackage

// File: rtl/snp_flush_sync.sv
module snp_flush_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_ni,
  output logic flush_req_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ~flush_ni};
  end

  // one request per assertion, however long it is held
  assign flush_req_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/snp_addr_hold.sv
module snp_addr_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ahold_i,
  output logic addr_oe_o
);
  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b1;
    else         oe_q <= ~ahold_i;
  end

  assign addr_oe_o = oe_q;
endmodule

// File: rtl/snp_inv_queue.sv
module snp_inv_queue #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/snp_tag_store.sv
module snp_tag_store #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned SETS   = 16,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              inv_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              inv_hit_o,
  output logic              lk_hit_o
);
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0] fill_idx, inv_idx, lk_idx;
  logic [TAG_W-1:0] fill_tag, inv_tag, lk_tag;
  logic [SETS-1:0]  valid_w;
  logic [TAG_W-1:0] tag_w [SETS];
  logic             unused_off;

  assign fill_idx = fill_addr_i[OFF_W +: IDX_W];
  assign inv_idx  = inv_addr_i[OFF_W +: IDX_W];
  assign lk_idx   = lk_addr_i[OFF_W +: IDX_W];
  assign fill_tag = fill_addr_i[ADDR_W-1 -: TAG_W];
  assign inv_tag  = inv_addr_i[ADDR_W-1 -: TAG_W];
  assign lk_tag   = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_off = ^{fill_addr_i[OFF_W-1:0], inv_addr_i[OFF_W-1:0], lk_addr_i[OFF_W-1:0]};

  assign inv_hit_o = inv_i & valid_w[inv_idx] & (tag_w[inv_idx] == inv_tag);
  assign lk_hit_o  = valid_w[lk_idx] & (tag_w[lk_idx] == lk_tag);

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             wr, kill;

    assign wr   = fill_i & (fill_idx == IDX_W'(g));
    // clear wins over a fill to the same set
    assign kill = (inv_hit_o & (inv_idx == IDX_W'(g))) |
                  (clr_i & (clr_idx_i == IDX_W'(g)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else begin
        if (kill)    v_q <= 1'b0;
        else if (wr) v_q <= 1'b1;
        if (wr)      t_q <= fill_tag;
      end
    end

    assign valid_w[g] = v_q;
    assign tag_w[g]   = t_q;
  end
endmodule

// File: rtl/snp_coherency_ctrl.sv
module snp_coherency_ctrl #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned OFF_W       = 2,
  parameter int unsigned SETS        = 16,
  parameter int unsigned Q_DEPTH     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ahold_i,
  input  logic              eads_ni,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              flush_ni,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              addr_oe_o,
  output logic              inv_valid_o,
  output logic [ADDR_W-1:0] inv_addr_o,
  output logic              inv_hit_o,
  output logic              flush_busy_o,
  output logic              lk_hit_o
);
  import snp_pkg::*;

  localparam int unsigned IDX_W = $clog2(SETS);

  flush_state_e     state_q;
  logic [IDX_W-1:0] set_q;
  logic             flush_req, q_empty, busy;

  snp_addr_hold u_ahold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ahold_i  (ahold_i),
    .addr_oe_o(addr_oe_o)
  );

  snp_flush_sync #(.STAGES(SYNC_STAGES)) u_fsync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_ni   (flush_ni),
    .flush_req_o(flush_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FL_IDLE;
      set_q   <= '0;
    end else begin
      case (state_q)
        FL_IDLE: if (flush_req) begin
          state_q <= FL_RUN;
          set_q   <= '0;
        end
        FL_RUN: begin
          set_q <= set_q + 1'b1;
          if (set_q == IDX_W'(SETS - 1)) state_q <= FL_IDLE;
        end
        default: state_q <= FL_IDLE;
      endcase
    end
  end

  assign busy         = (state_q == FL_RUN);
  assign flush_busy_o = busy;
  assign inv_valid_o  = ~q_empty & ~busy;

  snp_inv_queue #(.W(ADDR_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (~eads_ni),
    .data_i (snoop_addr_i),
    .pop_i  (inv_valid_o),
    .empty_o(q_empty),
    .data_o (inv_addr_o)
  );

  snp_tag_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_i     (fill_i),
    .fill_addr_i(fill_addr_i),
    .inv_i      (inv_valid_o),
    .inv_addr_i (inv_addr_o),
    .clr_i      (busy),
    .clr_idx_i  (set_q),
    .lk_addr_i  (lk_addr_i),
    .inv_hit_o  (inv_hit_o),
    .lk_hit_o   (lk_hit_o)
  );
endmodule

// File: rtl/snp_coherency_chk.sv
module snp_coherency_chk #(
  parameter int unsigned SETS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ahold_i,
  input logic addr_oe_o,
  input logic inv_valid_o,
  input logic flush_busy_o
);
  localparam int unsigned LW = $clog2(SETS) + 2;

  logic [LW-1:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           busy_len_q <= '0;
    else if (flush_busy_o) busy_len_q <= busy_len_q + 1'b1;
    else                   busy_len_q <= '0;
  end

  // R2
  oe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ahold_i |=> !addr_oe_o);

  // R2
  oe_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ahold_i |=> addr_oe_o);

  // R9
  no_inv_in_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_o |-> !inv_valid_o);

  // R7
  flush_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_busy_o) |-> (busy_len_q == LW'(SETS)));
endmodule

bind snp_coherency_ctrl snp_coherency_chk #(.SETS(SETS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ahold_i     (ahold_i),
  .addr_oe_o   (addr_oe_o),
  .inv_valid_o (inv_valid_o),
  .flush_busy_o(flush_busy_o)
);

// File: tb/tb_snp_coherency_ctrl.sv
module tb_snp_coherency_ctrl;
  localparam int unsigned AW = 16;
  localparam int unsigned NSETS = 16;
  localparam int unsigned QD = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ahold_i = 1'b0, eads_ni = 1'b1, flush_ni = 1'b1, fill_i = 1'b0;
  logic [AW-1:0] snoop_addr_i = '0, fill_addr_i = '0, lk_addr_i = '0;
  logic          addr_oe_o, inv_valid_o, inv_hit_o, flush_busy_o, lk_hit_o;
  logic [AW-1:0] inv_addr_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  snp_coherency_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .ahold_i(ahold_i), .eads_ni(eads_ni),
    .snoop_addr_i(snoop_addr_i), .flush_ni(flush_ni), .fill_i(fill_i),
    .fill_addr_i(fill_addr_i), .lk_addr_i(lk_addr_i), .addr_oe_o(addr_oe_o),
    .inv_valid_o(inv_valid_o), .inv_addr_o(inv_addr_o), .inv_hit_o(inv_hit_o),
    .flush_busy_o(flush_busy_o), .lk_hit_o(lk_hit_o)
  );

  typedef struct packed {
    logic [AW-1:0] fa;
    logic [AW-1:0] sa;
    logic          hit;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h1234, 16'h1234, 1'b1},
    '{16'h1234, 16'h1237, 1'b1},
    '{16'h2234, 16'h1234, 1'b0},
    '{16'h0040, 16'h0080, 1'b0},
    '{16'hFFFC, 16'hFFFF, 1'b1},
    '{16'h0000, 16'h0004, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_line(input logic [AW-1:0] a);
    fill_i = 1'b1; fill_addr_i = a;
    @(negedge clk);
    fill_i = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int busy_n, rises, n;
    logic prev;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(addr_oe_o == 1'b1, "R1 oe", addr_oe_o, 1);
    chk(flush_busy_o == 1'b0, "R1 busy", flush_busy_o, 0);
    chk(inv_valid_o == 1'b0, "R1 inv", inv_valid_o, 0);
    chk(lk_hit_o == 1'b0, "R1 lookup", lk_hit_o, 0);

    // R2 float timing
    ahold_i = 1'b1;
    #1 chk(addr_oe_o == 1'b1, "R2 before edge", addr_oe_o, 1);
    @(negedge clk);
    chk(addr_oe_o == 1'b0, "R2 floated", addr_oe_o, 0);
    // R3 fill and lookup keep working under hold
    fill_line(16'h5550);
    lk_addr_i = 16'h5550;
    #1 chk(lk_hit_o == 1'b1, "R3 fill under hold", lk_hit_o, 1);
    chk(addr_oe_o == 1'b0, "R2 still floated", addr_oe_o, 0);
    ahold_i = 1'b0;
    @(negedge clk);
    chk(addr_oe_o == 1'b1, "R2 restored", addr_oe_o, 1);
    ahold_i = 1'b1;
    @(negedge clk);
    ahold_i = 1'b0;
    chk(addr_oe_o == 1'b0, "R2 pulse low", addr_oe_o, 0);
    @(negedge clk);
    chk(addr_oe_o == 1'b1, "R2 pulse one clock", addr_oe_o, 1);

    // R4 R5 R6 vector walk
    foreach (VEC[i]) begin
      fill_line(VEC[i].fa);
      eads_ni = 1'b0; snoop_addr_i = VEC[i].sa;
      @(negedge clk);
      eads_ni = 1'b1;
      chk(inv_valid_o == 1'b1, "R4 issue", inv_valid_o, 1);
      chk(inv_addr_o == VEC[i].sa, "R4 addr", inv_addr_o, VEC[i].sa);
      chk(inv_hit_o == VEC[i].hit, "R5 hit flag", inv_hit_o, VEC[i].hit);
      @(negedge clk);
      lk_addr_i = VEC[i].fa;
      #1 chk(lk_hit_o == !VEC[i].hit, VEC[i].hit ? "R5 line gone" : "R6 line kept",
             lk_hit_o, !VEC[i].hit);
      chk(inv_valid_o == 1'b0, "R4 single issue", inv_valid_o, 0);
    end

    // R7 R8 R9 flush with queued strobes
    fill_line(16'h0100);
    fill_line(16'h0204);
    fill_line(16'h0308);
    flush_ni = 1'b0;
    @(negedge clk);
    flush_ni = 1'b1;
    chk(flush_busy_o == 1'b0, "R7 latency e0", flush_busy_o, 0);
    @(negedge clk);
    chk(flush_busy_o == 1'b0, "R7 latency e1", flush_busy_o, 0);
    @(negedge clk);
    chk(flush_busy_o == 1'b1, "R7 latency e2", flush_busy_o, 1);
    busy_n = 1;
    for (int k = 0; k < 6; k++) begin
      eads_ni = 1'b0; snoop_addr_i = 16'h0A00 + AW'(k * 4);
      @(negedge clk);
      if (flush_busy_o) busy_n++;
      chk(inv_valid_o == 1'b0, "R9 held off", inv_valid_o, 0);
    end
    eads_ni = 1'b1;
    for (int k = 0; k < 40 && flush_busy_o; k++) begin
      @(negedge clk);
      if (flush_busy_o) busy_n++;
    end
    chk(busy_n == NSETS, "R7 busy length", busy_n, NSETS);
    n = 0;
    for (int k = 0; k < 10 && inv_valid_o; k++) begin
      chk(inv_addr_o == 16'h0A00 + AW'(n * 4), "R9 order", inv_addr_o, 16'h0A00 + n * 4);
      n++;
      @(negedge clk);
    end
    chk(n == QD, "R9 queue depth", n, QD);
    lk_addr_i = 16'h0100; #1 chk(lk_hit_o == 1'b0, "R8 set0", lk_hit_o, 0);
    lk_addr_i = 16'h0204; #1 chk(lk_hit_o == 1'b0, "R8 set1", lk_hit_o, 0);
    lk_addr_i = 16'h0308; #1 chk(lk_hit_o == 1'b0, "R8 set2", lk_hit_o, 0);
    lk_addr_i = 16'h5550; #1 chk(lk_hit_o == 1'b0, "R8 set4", lk_hit_o, 0);

    // R7 long low level gives one walk
    @(negedge clk);
    flush_ni = 1'b0;
    rises = 0; prev = 1'b0;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      if (k == 39) flush_ni = 1'b1;
      if (flush_busy_o && !prev) rises++;
      prev = flush_busy_o;
    end
    chk(rises == 1, "R7 single walk", rises, 1);
    chk(flush_busy_o == 1'b0, "R7 idle after", flush_busy_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule